// File: doc/BRIEF.md
# Dual-Channel Prescaled PWM

Two independent pulse-width modulators share one clock and one word-addressed register port. Each channel owns a single 32-bit control word holding an enable flag, an 8-bit clock divisor and an 8-bit duty code. The divisor turns the input clock into slow ticks. Every output period lasts 256 of those ticks. Within a period the output is driven high for the first (256 − duty) ticks and low for the remainder.

The duty code is inverted: a small code gives a mostly-high waveform and a large code gives a mostly-low one. A duty code of zero holds the output low for the whole period. A divisor code of zero selects the largest division, 256. Software programs a channel by writing its word and starts or stops it with the top bit. Divisor or duty changes made while a channel runs wait for the end of the current period, so no period is ever cut short.

Top module: `dual_pwm`

## Requirements
- R1: Control word layout: bit 31 is enable, bits 15:8 are the divisor code and bits 7:0 are the duty code. A read returns the last written value of those fields, and bits 30:16 always read as zero. Clearing or setting the enable bit keeps the other two fields unchanged.
- R2: Word address 0 selects channel 0 and word address 1 selects channel 1. A write to one channel changes neither the word nor the output of the other channel.
- R3: One tick lasts D clock cycles, where D equals the divisor code for codes 1 to 255 and D = 256 for code 0.
- R4: A running period lasts 256 ticks. Over any window of 256·D consecutive cycles in steady state, the output is high for exactly (256 − duty)·D cycles when the duty code is between 1 and 255.
- R5: A duty code of 0 keeps the output low for the whole period. A duty code of 1 gives 255 high ticks, and 255 gives a single high tick.
- R6: Within each period the high part comes first. The output can only rise at the first tick of a period.
- R7: While the enable bit is 0, the output is low and the tick divider and period counter are held at zero. After enable is set, the first period starts from the beginning and uses the register values current at that moment.
- R8: Divisor and duty values written while a channel runs take effect only at the next period boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the addressed control word |
| reg_addr | input | 1 | Word address, equal to the channel number |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed control word (combinational) |
| pwm_out | output | 2 | PWM outputs, one bit per channel |

## Verification
The bench looks at the inverted duty ends: code 0 must stay low and must not wrap to full high, and codes 1 and 255 must give 255 and 1 high ticks rather than being off by one. It selects divisor code 0 across a whole 65536-cycle period; a design that treated that code as divide-by-one or as a stall would show a very different high count. It changes the duty in the middle of a period, where a design without deferral would produce one distorted period that the cycle-level model catches. It also disables and re-enables a channel, and writes ones into the reserved bits, to catch counters that are not cleared and reserved bits that leak into reads.

// File: rtl/dual_pwm.sv
`timescale 1ns/1ps
module dual_pwm #(
  parameter int NCH = 2,
  parameter int DW  = 8,
  parameter int AW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int PADW = 31 - 2*DW;
  localparam logic [DW-1:0] CMAX = {DW{1'b1}};

  logic [NCH-1:0]         en_q, run_q, tick;
  logic [NCH-1:0][DW-1:0] rel_q, dut_q, sh_rel, sh_dut, presc, cnt, div_m1;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          sel, load;
    logic [DW:0]   sum;

    assign sel       = reg_wr && (reg_addr == AW'(i));
    assign div_m1[i] = (sh_rel[i] == '0) ? CMAX : sh_rel[i] - 1'b1;
    assign tick[i]   = (presc[i] == div_m1[i]);
    assign load      = !run_q[i] || !en_q[i] || (tick[i] && cnt[i] == CMAX);
    assign sum       = {1'b0, cnt[i]} + {1'b0, sh_dut[i]};
    assign pwm_out[i] = en_q[i] && run_q[i] && (sh_dut[i] != '0) && !sum[DW];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[i]   <= 1'b0;
        rel_q[i]  <= '0;
        dut_q[i]  <= '0;
        run_q[i]  <= 1'b0;
        sh_rel[i] <= '0;
        sh_dut[i] <= '0;
        presc[i]  <= '0;
        cnt[i]    <= '0;
      end else begin
        if (sel) begin
          en_q[i]  <= reg_wdata[31];
          rel_q[i] <= reg_wdata[2*DW-1:DW];
          dut_q[i] <= reg_wdata[DW-1:0];
        end
        run_q[i] <= en_q[i];
        if (load) begin
          sh_rel[i] <= rel_q[i];
          sh_dut[i] <= dut_q[i];
        end
        if (!en_q[i] || !run_q[i]) begin
          presc[i] <= '0;
          cnt[i]   <= '0;
        end else if (tick[i]) begin
          presc[i] <= '0;
          cnt[i]   <= cnt[i] + 1'b1;
        end else begin
          presc[i] <= presc[i] + 1'b1;
        end
      end
    end

    assert_prescale_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      presc[i] <= div_m1[i]);

    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && run_q[i] && tick[i]) |=> cnt[i] == $past(cnt[i]) + 1'b1);

    assert_rise_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out[i]) |-> (cnt[i] == '0));

    assert_idle_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[i] |=> (presc[i] == '0 && cnt[i] == '0 && !pwm_out[i]));

    assert_deferred_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q[i] && $past(run_q[i]) &&
       (sh_dut[i] != $past(sh_dut[i]) || sh_rel[i] != $past(sh_rel[i])))
      |-> ($past(cnt[i]) == CMAX && $past(tick[i])));
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (reg_addr == AW'(i))
        reg_rdata = {en_q[i], {PADW{1'b0}}, rel_q[i], dut_q[i]};
  end
endmodule

// File: tb/dual_pwm_bench.sv
`timescale 1ns/1ps
module dual_pwm_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [0:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  pwm_out;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  dual_pwm u_dual_pwm (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  // behavioural reference, one entry per channel
  int m_en[2], m_rel[2], m_dut[2], m_run[2];
  int m_srel[2], m_sdut[2], m_phase[2], m_tick[2];

  function automatic bit exp_out(int c);
    return m_en[c] != 0 && m_run[c] != 0 && m_sdut[c] != 0 && m_tick[c] < 256 - m_sdut[c];
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (!rst_n) begin
        m_en[c] = 0; m_rel[c] = 0; m_dut[c] = 0; m_run[c] = 0;
        m_srel[c] = 0; m_sdut[c] = 0; m_phase[c] = 0; m_tick[c] = 0;
      end else begin
        int d;
        d = (m_srel[c] == 0) ? 256 : m_srel[c];
        if (m_en[c] == 0 || m_run[c] == 0) begin
          m_phase[c] = 0; m_tick[c] = 0;
          m_srel[c] = m_rel[c]; m_sdut[c] = m_dut[c];
        end else if (m_phase[c] == d - 1) begin
          m_phase[c] = 0;
          if (m_tick[c] == 255) begin
            m_tick[c] = 0; m_srel[c] = m_rel[c]; m_sdut[c] = m_dut[c];
          end else m_tick[c] = m_tick[c] + 1;
        end else m_phase[c] = m_phase[c] + 1;
        m_run[c] = m_en[c];
        if (reg_wr && reg_addr == c[0:0]) begin
          m_en[c]  = reg_wdata[31];
          m_rel[c] = reg_wdata[15:8];
          m_dut[c] = reg_wdata[7:0];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        checks++;
        if (pwm_out[c] !== exp_out(c)) begin
          failures++;
          $display("FAIL model R3 R4 R5 R6 R7 R8 ch%0d got %b exp %b at %0t",
                   c, pwm_out[c], exp_out(c), $time);
        end
      end
    end
  end

  task automatic wr(input int ch, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ch[0:0]; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input int ch, input logic [31:0] exp, input string tag);
    reg_addr = ch[0:0];
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      failures++;
      $display("FAIL %s read ch%0d got %h exp %h", tag, ch, reg_rdata, exp);
    end
  endtask

  task automatic measure(input int ch, input int n, input int exp, input string tag);
    int hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
      if (pwm_out[ch]) hi++;
    end
    checks++;
    if (hi != exp) begin
      failures++;
      $display("FAIL %s ch%0d high count got %0d exp %0d", tag, ch, hi, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] cw(input bit en, input int rel, input int dut);
    return {en, 15'd0, rel[7:0], dut[7:0]};
  endfunction

  initial begin
    #1000000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    #1;
    checks++;
    if (pwm_out !== 2'b00) begin
      failures++; $display("FAIL R7 reset output got %b exp 00", pwm_out);
    end
    rd_check(0, 32'h0, "R1");
    rst_n = 1'b1;
    idle(2);

    wr(0, cw(1, 1, 128));
    rd_check(0, cw(1, 1, 128), "R1");
    rd_check(1, 32'h0, "R2");
    idle(10);
    measure(0, 256, 128, "R4");
    measure(1, 256, 0, "R2");

    wr(1, cw(1, 3, 1));
    idle(5);
    measure(1, 768, 765, "R3 R5");

    wr(0, cw(0, 1, 128));
    rd_check(0, cw(0, 1, 128), "R1");
    measure(0, 300, 0, "R7");
    rd_check(1, cw(1, 3, 1), "R2");

    wr(0, cw(1, 1, 0));
    idle(5);
    measure(0, 256, 0, "R5");

    wr(0, cw(1, 2, 255));
    idle(600);
    measure(0, 512, 2, "R5");

    wr(0, cw(0, 1, 200));
    idle(3);
    wr(0, cw(1, 1, 200));
    idle(300);
    wr(0, cw(1, 1, 56));
    idle(300);
    measure(0, 256, 200, "R8");

    wr(1, 32'h7FFF_0000 | cw(1, 0, 128));
    rd_check(1, cw(1, 0, 128), "R1");
    idle(1000);
    measure(1, 65536, 32768, "R3");

    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule